// File: doc/BRIEF.md
# Serial Channel Queue and Interrupt Controller

This block sits between the host register port of one asynchronous serial channel and that channel's shift logic. It keeps a receive byte queue and a transmit byte queue. Each receive entry carries three error flags beside its data byte. From the queue state it produces the host's view: a line status byte, an encoded interrupt status byte, one interrupt line, and two active-low DMA-style ready strobes. Framing, bit timing and the modem pins belong to neighbouring blocks. The modem logic hands in only a level that says a modem interrupt is wanted.

The host writes a queue control register with the following fields:
- bit 0 turns queue mode on or off;
- bits 1 and 2 are one-shot clears;
- bits 7:6 pick the receive threshold.

With queue mode off, each direction behaves as a single holding register. The receive shift logic pushes bytes with their error flags. The transmit shift logic pops bytes whenever `tx_avail` is high. The host reads received bytes and writes bytes to transmit through the data address. Reading the status registers acknowledges some interrupt causes.

Top module: `uart_queue_irq`

## Requirements
- R1: After reset the register reads are:
  - interrupt status (address 2) reads 0x01;
  - enable mask (address 1) reads 0x00;
  - control readback (address 3) reads 0x00;
  - line status (address 5) reads 0x60.

  The outputs are rxrdy_n=1, txrdy_n=0, irq=0 and tx_avail=0.
- R2: Queue capacity is 16 bytes per direction in queue mode and 1 byte with queue mode off. A push into a full queue is dropped. A dropped receive push sets line status bit 1 (overrun), and a line status read clears it. Whether a push is accepted depends on the count at the start of the cycle.
- R3: Bytes leave each queue in the order they entered. Received bytes are read at address 0. Transmit bytes written at address 0 appear on tx_byte, one per tx_pop.
- R4: Control bits 7:6 codes 00, 01, 10 and 11 give receive thresholds of 1, 4, 8 and 14 bytes. With queue mode off the threshold is 1. When enable bit 0 is set and the receive count is at or above the threshold, the receive-data interrupt (identifier 010) is pending.
- R5: rxrdy_n goes low in the cycle the receive count reaches the threshold. It stays low until the receive queue is empty, even if the count drops below the threshold.
- R6: txrdy_n is high exactly while the transmit queue is full: 16 bytes in queue mode, 1 byte otherwise.
- R7: Writes to address 2 go to the control register:
  - bit 1 empties the receive queue;
  - bit 2 empties the transmit queue;
  - a write that changes bit 0 empties both queues.

  Bits 1 and 2 do not persist. Address 3 reads {bits 7:6, 5'b0, bit 0}.
- R8: Enable mask bits 7:4 and control readback bits 5:1 always read 0. Enable mask bits 3:0 read back as written.
- R9: Line status bits 2, 3 and 4 show the parity, framing and break flags (rx_err bits 0, 1, 2) of the byte at the head of the receive queue. They read 0 when the queue is empty. With enable bit 2 set, the line status interrupt (identifier 011) is pending while overrun is set or the head byte has any error flag.
- R10: Line status bit 0 is high when the receive queue is non-empty. Bit 5 is high when the transmit queue is empty. Bit 6 is high when the transmit queue is empty and tx_busy is low.
- R11: A transmit-empty flag is set in three cases: a pop or a clear drains the transmit queue, or enable bit 1 rises while the queue is empty. Two events clear the flag: a data write, or an interrupt status read that reports identifier 001. With enable bit 1 set, the flag raises the transmit-empty interrupt.
- R12: Interrupt status reads {en, en, 2'b00, id[2:0], not-pending}. Priority runs line status (011), then receive data (010), then transmit empty (001), then modem (000, from modem_int with enable bit 3). irq equals pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (side effects at the clock edge) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational from the address |
| rx_push | input | 1 | Receive shift logic delivers a byte |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 3 | Error flags {break, framing, parity} of the received byte |
| tx_pop | input | 1 | Transmit shift logic takes the head byte |
| tx_byte | output | 8 | Head of the transmit queue |
| tx_avail | output | 1 | Transmit queue is non-empty |
| tx_busy | input | 1 | Transmit shifter is still sending |
| modem_int | input | 1 | Modem interrupt request level |
| rxrdy_n | output | 1 | Receive ready, active low |
| txrdy_n | output | 1 | Transmit ready, active low (high when full) |
| irq | output | 1 | Interrupt request, active high |

## Verification
Every strobe is registered at one clock edge. The results of a strobe show on reg_rdata, irq, rxrdy_n, txrdy_n and tx_avail one nanosecond after that edge, and are then steady for the rest of the cycle. The read data and the head byte are combinational from the current state. The bench therefore samples them in the same cycle the strobe is driven, just after the falling edge and before the edge that applies the read's side effect. Sweeps cover:
- every value of the enable mask and the control byte;
- all four thresholds, filling the receive queue one byte at a time to 16 and overrun, then draining it;
- holding mode in both directions;
- each error flag;
- the interrupt priority chain.

// File: rtl/uart_qi_pkg.sv
package uart_qi_pkg;

    localparam int QDEPTH = 16;
    localparam int ERRW   = 3;

    localparam logic [2:0] ADDR_DATA = 3'd0;
    localparam logic [2:0] ADDR_MASK = 3'd1;
    localparam logic [2:0] ADDR_CTRL = 3'd2;
    localparam logic [2:0] ADDR_CRB  = 3'd3;
    localparam logic [2:0] ADDR_LINE = 3'd5;

    typedef enum logic [2:0] {
        ID_MODEM = 3'b000,
        ID_TXE   = 3'b001,
        ID_RXD   = 3'b010,
        ID_LINE  = 3'b011
    } irq_id_e;

    function automatic int trig_level(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_qi_fifo.sv
module uart_qi_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          single,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    int       cap;
    logic     do_push, do_pop;

    assign cap     = single ? 1 : DEPTH;
    assign full    = int'(st_q.cnt) >= cap;
    assign empty   = (st_q.cnt == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign rdata   = st_q.mem[st_q.rp];
    assign count   = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = wdata;
                st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            end
            if (do_pop) begin
                st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/uart_qi_prio.sv
module uart_qi_prio
    import uart_qi_pkg::*;
(
    input  logic    src_line,
    input  logic    src_rxd,
    input  logic    src_txe,
    input  logic    src_modem,
    output logic    pending,
    output irq_id_e id
);

    always_comb begin
        pending = 1'b1;
        if (src_line)       id = ID_LINE;
        else if (src_rxd)   id = ID_RXD;
        else if (src_txe)   id = ID_TXE;
        else begin
            id      = ID_MODEM;
            pending = src_modem;
        end
    end

endmodule

// File: rtl/uart_queue_irq.sv
module uart_queue_irq
    import uart_qi_pkg::*;
#(
    parameter int DEPTH = QDEPTH,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int RXW  = 8 + ERRW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [2:0]      reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic            rx_push,
    input  logic [7:0]      rx_byte,
    input  logic [ERRW-1:0] rx_err,
    input  logic            tx_pop,
    output logic [7:0]      tx_byte,
    output logic            tx_avail,
    input  logic            tx_busy,
    input  logic            modem_int,
    output logic            rxrdy_n,
    output logic            txrdy_n,
    output logic            irq
);

    typedef struct packed {
        logic [3:0] mask;
        logic       q_en;
        logic [1:0] trig;
        logic       overrun;
        logic       txe;
        logic       rx_hold;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic wr_data, rd_data, wr_mask, wr_ctrl, rd_isr, rd_line;
    logic en_change, rx_flush, tx_flush;

    logic [RXW-1:0]  rx_head;
    logic [CW-1:0]   rx_cnt, tx_cnt;
    logic            rx_full, rx_empty, tx_full, tx_empty;
    logic [ERRW-1:0] head_err;
    int              rx_lvl;
    logic            rx_at_lvl, rxrdy_now;

    logic    src_line, src_rxd, src_txe, src_modem, pending;
    irq_id_e cur_id;
    logic    tx_drained;

    assign wr_data = reg_wr & (reg_addr == ADDR_DATA);
    assign rd_data = reg_rd & (reg_addr == ADDR_DATA);
    assign wr_mask = reg_wr & (reg_addr == ADDR_MASK);
    assign wr_ctrl = reg_wr & (reg_addr == ADDR_CTRL);
    assign rd_isr  = reg_rd & (reg_addr == ADDR_CTRL);
    assign rd_line = reg_rd & (reg_addr == ADDR_LINE);

    assign en_change = wr_ctrl & (reg_wdata[0] != st_q.q_en);
    assign rx_flush  = wr_ctrl & (reg_wdata[1] | en_change);
    assign tx_flush  = wr_ctrl & (reg_wdata[2] | en_change);

    uart_qi_fifo #(.DEPTH(DEPTH), .W(RXW)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .single(~st_q.q_en),
        .push  (rx_push),
        .pop   (rd_data),
        .wdata ({rx_err, rx_byte}),
        .rdata (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    uart_qi_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .single(~st_q.q_en),
        .push  (wr_data),
        .pop   (tx_pop),
        .wdata (reg_wdata),
        .rdata (tx_byte),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    assign head_err  = rx_empty ? '0 : rx_head[RXW-1:8];
    assign rx_lvl    = st_q.q_en ? trig_level(st_q.trig) : 1;
    assign rx_at_lvl = int'(rx_cnt) >= rx_lvl;
    assign rxrdy_now = rx_at_lvl | (st_q.rx_hold & ~rx_empty);

    assign src_line  = st_q.mask[2] & (st_q.overrun | (|head_err));
    assign src_rxd   = st_q.mask[0] & rx_at_lvl;
    assign src_txe   = st_q.mask[1] & st_q.txe;
    assign src_modem = st_q.mask[3] & modem_int;

    uart_qi_prio u_prio (
        .src_line (src_line),
        .src_rxd  (src_rxd),
        .src_txe  (src_txe),
        .src_modem(src_modem),
        .pending  (pending),
        .id       (cur_id)
    );

    assign tx_drained = (tx_pop & (tx_cnt == CW'(1)) & ~wr_data)
                      | (tx_flush & ~tx_empty)
                      | (wr_mask & reg_wdata[1] & ~st_q.mask[1] & tx_empty);

    always_comb begin
        st_d = st_q;
        if (wr_mask) st_d.mask = reg_wdata[3:0];
        if (wr_ctrl) begin
            st_d.q_en = reg_wdata[0];
            st_d.trig = reg_wdata[7:6];
        end
        if (rd_line)            st_d.overrun = 1'b0;
        if (rx_push & rx_full)  st_d.overrun = 1'b1;
        if (wr_data | (rd_isr & pending & (cur_id == ID_TXE))) st_d.txe = 1'b0;
        if (tx_drained)         st_d.txe = 1'b1;
        st_d.rx_hold = rxrdy_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            ADDR_DATA: reg_rdata = rx_head[7:0];
            ADDR_MASK: reg_rdata = {4'b0000, st_q.mask};
            ADDR_CTRL: reg_rdata = {st_q.q_en, st_q.q_en, 2'b00, cur_id, ~pending};
            ADDR_CRB:  reg_rdata = {st_q.trig, 5'b00000, st_q.q_en};
            ADDR_LINE: reg_rdata = {1'b0, tx_empty & ~tx_busy, tx_empty,
                                    head_err, st_q.overrun, ~rx_empty};
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign tx_avail = ~tx_empty;
    assign txrdy_n  = tx_full;
    assign rxrdy_n  = ~rxrdy_now;
    assign irq      = pending;

endmodule

// File: rtl/uart_qi_check.sv
module uart_qi_check #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          q_en,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] tx_cnt,
    input logic          rx_push,
    input logic          rx_flush,
    input logic          overrun,
    input logic          rxrdy_n,
    input logic          txrdy_n
);

    int cap;
    assign cap = q_en ? DEPTH : 1;

    assert_rx_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rx_cnt) <= cap);

    assert_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && int'(rx_cnt) == cap) |=> overrun);

    assert_txrdy_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        txrdy_n == (int'(tx_cnt) == cap));

    assert_rxrdy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rxrdy_n |=> (!rxrdy_n || rx_cnt == '0));

    assert_rx_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> rx_cnt == '0);

endmodule

bind uart_queue_irq uart_qi_check #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .q_en    (st_q.q_en),
    .rx_cnt  (rx_cnt),
    .tx_cnt  (tx_cnt),
    .rx_push (rx_push),
    .rx_flush(rx_flush),
    .overrun (st_q.overrun),
    .rxrdy_n (rxrdy_n),
    .txrdy_n (txrdy_n)
);

// File: tb/uart_queue_irq_test.sv
`timescale 1ns/1ps
module uart_queue_irq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_push = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [2:0] rx_err = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_byte;
    logic       tx_avail;
    logic       tx_busy = 1'b0;
    logic       modem_int = 1'b0;
    logic       rxrdy_n, txrdy_n, irq;

    int nvec = 0;
    int nbad = 0;
    logic [7:0] v;

    always #10 clk = ~clk;

    uart_queue_irq uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_err(rx_err),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_avail(tx_avail),
        .tx_busy(tx_busy), .modem_int(modem_int),
        .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] e);
        @(negedge clk);
        rx_byte = d; rx_err = e; rx_push = 1'b1;
        @(posedge clk); #1 rx_push = 1'b0;
    endtask

    task automatic pop(output logic [7:0] d);
        @(negedge clk);
        tx_pop = 1'b1;
        #1 d = tx_byte;
        @(posedge clk); #1 tx_pop = 1'b0;
    endtask

    function automatic int lvl_of(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd2, v); chk("R1 isr", v, 8'h01);
        rd(3'd1, v); chk("R1 mask", v, 8'h00);
        rd(3'd3, v); chk("R1 ctrl", v, 8'h00);
        rd(3'd5, v); chk("R1 line", v, 8'h60);
        chk("R1 rxrdy_n", rxrdy_n, 1);
        chk("R1 txrdy_n", txrdy_n, 0);
        chk("R1 irq", irq, 0);
        chk("R1 tx_avail", tx_avail, 0);

        // R8 R7 readback sweeps
        for (int i = 0; i < 256; i++) begin
            wr(3'd1, 8'(i)); rd(3'd1, v);
            chk("R8 mask readback", v, i & 8'h0F);
        end
        for (int i = 0; i < 256; i++) begin
            wr(3'd2, 8'(i)); rd(3'd3, v);
            chk("R7 ctrl readback", v, (i & 8'hC0) | (i & 8'h01));
        end

        // R4 R5 R2 R3 threshold sweep
        for (int c = 0; c < 4; c++) begin
            int lv;
            lv = lvl_of(c);
            wr(3'd2, 8'(c << 6) | 8'h07);
            wr(3'd1, 8'h01);
            for (int k = 1; k <= 16; k++) begin
                push(8'(k * 7 + c), 3'b000);
                chk("R5 rxrdy_n fill", rxrdy_n, (k >= lv) ? 0 : 1);
                chk("R4 irq fill", irq, (k >= lv) ? 1 : 0);
                rd(3'd2, v);
                chk("R4 isr fill", v, (k >= lv) ? 8'hC4 : 8'hC1);
            end
            push(8'hEE, 3'b000);
            rd(3'd5, v); chk("R2 overrun set", v, 8'h63);
            rd(3'd5, v); chk("R2 overrun cleared", v, 8'h61);
            for (int j = 1; j <= 16; j++) begin
                rd(3'd0, v);
                chk("R3 rx order", v, 8'(j * 7 + c));
                chk("R5 rxrdy_n drain", rxrdy_n, (j == 16) ? 1 : 0);
                chk("R4 irq drain", irq, (16 - j >= lv) ? 1 : 0);
            end
        end

        // R2 R6 holding mode
        wr(3'd2, 8'h00);
        chk("R2 hold rxrdy_n idle", rxrdy_n, 1);
        push(8'h5A, 3'b000);
        chk("R5 hold rxrdy_n", rxrdy_n, 0);
        rd(3'd5, v); chk("R10 hold line", v, 8'h61);
        push(8'hA5, 3'b000);
        rd(3'd0, v); chk("R2 hold keeps first", v, 8'h5A);
        rd(3'd5, v); chk("R2 hold overrun", v, 8'h62);
        rd(3'd2, v); chk("R12 isr queue off", v, 8'h01);
        chk("R6 hold txrdy_n empty", txrdy_n, 0);
        wr(3'd0, 8'h3C);
        chk("R6 hold txrdy_n full", txrdy_n, 1);
        chk("R3 hold tx_avail", tx_avail, 1);
        wr(3'd0, 8'h44);
        pop(v); chk("R2 hold tx byte", v, 8'h3C);
        chk("R6 hold txrdy_n after pop", txrdy_n, 0);
        chk("R2 hold second dropped", tx_avail, 0);

        // R6 R3 R10 R11 transmit queue
        wr(3'd2, 8'h07);
        wr(3'd1, 8'h00);
        wr(3'd1, 8'h02);
        chk("R11 irq on enable", irq, 1);
        rd(3'd2, v); chk("R11 isr txe", v, 8'hC2);
        rd(3'd2, v); chk("R11 cleared by read", v, 8'hC1);
        for (int k = 1; k <= 16; k++) begin
            wr(3'd0, 8'(k + 8'h30));
            chk("R6 txrdy_n fill", txrdy_n, (k == 16) ? 1 : 0);
        end
        rd(3'd5, v); chk("R10 line tx full", v, 8'h00);
        tx_busy = 1'b1;
        for (int j = 1; j <= 16; j++) begin
            pop(v); chk("R3 tx order", v, 8'(j + 8'h30));
        end
        chk("R11 irq after drain", irq, 1);
        rd(3'd5, v); chk("R10 line busy", v, 8'h20);
        tx_busy = 1'b0;
        rd(3'd5, v); chk("R10 line idle", v, 8'h60);
        wr(3'd0, 8'h77);
        chk("R11 cleared by write", irq, 0);
        rd(3'd2, v); chk("R11 isr after write", v, 8'hC1);
        wr(3'd2, 8'h05);
        chk("R7 tx cleared", tx_avail, 0);
        rd(3'd2, v); chk("R11 set by clear", v, 8'hC2);
        rd(3'd2, v); chk("R11 read clears", v, 8'hC1);

        // R9 R12 errors and priority
        wr(3'd1, 8'h00);
        modem_int = 1'b1;
        wr(3'd1, 8'h0F);
        rd(3'd2, v); chk("R12 txe over modem", v, 8'hC2);
        rd(3'd2, v); chk("R12 modem", v, 8'hC0);
        push(8'h11, 3'b001);
        rd(3'd2, v); chk("R12 line highest", v, 8'hC6);
        rd(3'd5, v); chk("R9 parity head", v, 8'h65);
        push(8'h22, 3'b000);
        rd(3'd0, v); chk("R3 err byte data", v, 8'h11);
        rd(3'd5, v); chk("R9 clean head", v, 8'h61);
        rd(3'd2, v); chk("R12 rx over modem", v, 8'hC4);
        rd(3'd0, v); chk("R3 second data", v, 8'h22);
        rd(3'd2, v); chk("R12 modem again", v, 8'hC0);
        modem_int = 1'b0;
        @(negedge clk); #1 chk("R12 irq idle", irq, 0);
        rd(3'd2, v); chk("R12 none pending", v, 8'hC1);
        push(8'h33, 3'b010);
        rd(3'd5, v); chk("R9 framing head", v, 8'h69);
        rd(3'd2, v); chk("R9 line irq", v, 8'hC6);
        rd(3'd0, v);
        push(8'h44, 3'b100);
        rd(3'd5, v); chk("R9 break head", v, 8'h71);
        rd(3'd0, v);
        rd(3'd5, v); chk("R9 empty no flags", v, 8'h60);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule